// File: doc/BRIEF.md
# Column Multiple-Sampling Slope Counter

This block is the digital half of one column of a single-slope converter that performs correlated multiple sampling. An external ramp comparator reports, through one asynchronous bit, when the ramp has crossed the pixel level. For every conversion the block counts clocks from the ramp-start strobe until the synchronized comparator bit goes high. Reset-level conversions count the accumulator down and signal-level conversions count it up. After M reset/signal pairs the accumulator therefore holds M times the correlated difference. Reset noise and fixed offsets cancel, and the low-noise result carries a digital gain of M.

A column sequencer pulses `start_i` with the pair count selected on `m_log2_i`. For each sample it sets `phase_sig_i` and pulses `ramp_go_i` as the analog ramp begins. The comparator, ramp and pixel are outside the block. The result is a status word, not a stream. It is valid and held from the `done_o` pulse until the next start. The column readout latches it, so no back-pressure path exists.

Top module: `cms_ss_counter`

## Requirements
- R1: After reset `result_o` is 0 and `done_o` is 0.
- R2: A `start_i` pulse clears `result_o` to 0 on the next edge and arms a sequence of M pairs, where M = 2^`m_log2_i`.
- R3: Latency of a conversion count. The accepted `ramp_go_i` edge is edge 0. If `cmp_i` (1 = ramp has crossed) is first sampled high at edge a (a ≥ 1), the sample count is a+1. This covers two synchronizer flops plus the stopping edge. A comparator already high through the synchronizer gives a count of 0.
- R4: `phase_sig_i` = 0 marks a reset phase and its count is subtracted. `phase_sig_i` = 1 marks a signal phase and its count is added. `result_o` is two's complement, N + log2(Mmax) + 1 bits wide.
- R5: A sample whose comparator does not trip stops counting at 2^N − 1.
- R6: `done_o` is high for exactly one cycle. That cycle follows the edge at which the M-th signal conversion stops. `result_o` is final then and holds until the next start.
- R7: `ramp_go_i` is ignored while no sequence is armed, and while a conversion is counting. An ignored strobe changes neither the count nor the result.
- R8: `m_log2_i` values above 4 select M = 16.
- R9: A `start_i` in the same cycle as the final conversion's stop takes priority. The result clears, no `done_o` pulse is produced, and the new sequence starts.
- R10: M identical pairs produce exactly M times the single-pair difference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the accumulator and arms a new M-pair sequence |
| m_log2_i | input | 3 | log2 of pair count, clamped to 4 |
| ramp_go_i | input | 1 | Ramp-start strobe, begins one conversion |
| phase_sig_i | input | 1 | 0 = reset-level sample, 1 = signal-level sample |
| cmp_i | input | 1 | Asynchronous comparator output, 1 once ramp passes level |
| result_o | output | 13 | Signed accumulated difference |
| done_o | output | 1 | One-cycle pulse when the sequence completes |

## Verification
A new start and the stopping edge of the last signal conversion can fall in the same cycle. In that cycle a clear and the final update of the accumulator, plus the completion pulse, compete. The bench raises `start_i` in exactly the cycle in which the synchronized trip ends the count. That cycle is computed from the R3 latency. The bench then requires a zero result and no `done_o` pulse. A following fresh pair must produce the correct value from zero.

// File: rtl/cms_pkg.sv
package cms_pkg;
  typedef enum logic {
    PH_RESET  = 1'b0,
    PH_SIGNAL = 1'b1
  } phase_e;
endpackage

// File: rtl/cms_sync2.sv
module cms_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/cms_slope_cnt.sv
module cms_slope_cnt #(
  parameter int CNT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic active_i,
  input  logic trip_i,
  output logic tick_o,
  output logic end_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  // stop on synchronized trip or at full scale
  assign end_o  = active_i && (trip_i || (cnt_q == CNT_MAX));
  assign tick_o = active_i && !end_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (launch_i) cnt_q <= '0;
    else if (tick_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cms_pair_seq.sv
module cms_pair_seq
  import cms_pkg::*;
#(
  parameter int LOG2M_MAX = 4,
  parameter int SEL_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] m_log2_i,
  input  logic             ramp_go_i,
  input  logic             phase_sig_i,
  input  logic             conv_end_i,
  output logic             active_o,
  output phase_e           phase_o,
  output logic             launch_o,
  output logic             done_o
);
  localparam int PAIR_W = LOG2M_MAX + 1;

  logic              busy_q, active_q, done_q;
  phase_e            phase_q;
  logic [PAIR_W-1:0] left_q;
  logic [PAIR_W-1:0] pairs_sel;
  logic              last_end;

  always_comb begin
    if (int'(m_log2_i) > LOG2M_MAX) pairs_sel = PAIR_W'(1) << LOG2M_MAX;
    else                            pairs_sel = PAIR_W'(1) << m_log2_i;
  end

  assign launch_o = busy_q && !active_q && ramp_go_i && !start_i;
  assign last_end = active_q && conv_end_i && (phase_q == PH_SIGNAL)
                    && (left_q == PAIR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      phase_q  <= PH_RESET;
      left_q   <= '0;
    end else if (start_i) begin
      busy_q   <= 1'b1;
      active_q <= 1'b0;
      done_q   <= 1'b0;
      left_q   <= pairs_sel;
    end else begin
      done_q <= last_end;
      if (launch_o) begin
        active_q <= 1'b1;
        phase_q  <= phase_sig_i ? PH_SIGNAL : PH_RESET;
      end else if (active_q && conv_end_i) begin
        active_q <= 1'b0;
        if (phase_q == PH_SIGNAL) begin
          left_q <= left_q - 1'b1;
          if (left_q == PAIR_W'(1)) busy_q <= 1'b0;
        end
      end
    end
  end

  assign active_o = active_q;
  assign phase_o  = phase_q;
  assign done_o   = done_q;
endmodule

// File: rtl/cms_updown_acc.sv
module cms_updown_acc #(
  parameter int ACC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic             up_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (tick_i)  acc_q <= up_i ? acc_q + 1'b1 : acc_q - 1'b1;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cms_ss_counter.sv
module cms_ss_counter
  import cms_pkg::*;
#(
  parameter  int CNT_W     = 8,
  parameter  int LOG2M_MAX = 4,
  localparam int SEL_W     = $clog2(LOG2M_MAX + 1),
  localparam int ACC_W     = CNT_W + LOG2M_MAX + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [SEL_W-1:0] m_log2_i,
  input  logic             ramp_go_i,
  input  logic             phase_sig_i,
  input  logic             cmp_i,
  output logic [ACC_W-1:0] result_o,
  output logic             done_o
);
  logic   cmp_sync, conv_active, conv_launch, conv_end, cnt_tick;
  phase_e conv_phase;

  cms_sync2 u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(cmp_i), .sync_o(cmp_sync)
  );

  cms_pair_seq #(.LOG2M_MAX(LOG2M_MAX), .SEL_W(SEL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .m_log2_i(m_log2_i),
    .ramp_go_i(ramp_go_i), .phase_sig_i(phase_sig_i), .conv_end_i(conv_end),
    .active_o(conv_active), .phase_o(conv_phase), .launch_o(conv_launch),
    .done_o(done_o)
  );

  cms_slope_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .launch_i(conv_launch), .active_i(conv_active),
    .trip_i(cmp_sync), .tick_o(cnt_tick), .end_o(conv_end)
  );

  cms_updown_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_i(start_i), .tick_i(cnt_tick),
    .up_i(conv_phase == PH_SIGNAL), .acc_o(result_o)
  );
endmodule

// File: rtl/cms_ss_counter_chk.sv
module cms_ss_counter_chk #(
  parameter int ACC_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             conv_active,
  input logic [ACC_W-1:0] result_o,
  input logic             done_o
);
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (result_o == '0));

  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_active && !start_i) |=> ((result_o == $past(result_o)) ||
      (result_o == $past(result_o) + ACC_W'(1)) ||
      (result_o == $past(result_o) - ACC_W'(1))));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_active && !start_i) |=> $stable(result_o));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_after_conv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(conv_active));

  p_start_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);
endmodule

bind cms_ss_counter cms_ss_counter_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .conv_active(conv_active),
  .result_o(result_o), .done_o(done_o)
);

// File: tb/cms_ss_counter_tb_top.sv
module cms_ss_counter_tb_top;
  localparam int CNT_W = 8;
  localparam int ACC_W = 13;
  localparam int FULL  = 255;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] m_log2_i = '0;
  logic ramp_go_i = 1'b0;
  logic phase_sig_i = 1'b0;
  logic cmp_i = 1'b0;
  logic [ACC_W-1:0] result_o;
  logic done_o;

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cms_ss_counter #(.CNT_W(CNT_W), .LOG2M_MAX(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .m_log2_i(m_log2_i),
    .ramp_go_i(ramp_go_i), .phase_sig_i(phase_sig_i), .cmp_i(cmp_i),
    .result_o(result_o), .done_o(done_o)
  );

  always @(negedge clk) if (rst_n && done_o) done_cnt++;

  function automatic int res();
    return int'($signed(result_o));
  endfunction

  function automatic int exp_cnt(input int v);
    return (v + 2 > FULL) ? FULL : v + 2;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_start(input int m);
    start_i = 1'b1;
    m_log2_i = 3'(m);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // one conversion; comparator high once ramp (edges since launch) >= v
  task automatic do_conv(input bit ph, input int v, input int extra_go_at,
                         input int start_at);
    int lim;
    lim = exp_cnt(v) + 3;
    phase_sig_i = ph;
    ramp_go_i = 1'b1;
    @(negedge clk);
    for (int r = 0; r <= lim; r++) begin
      cmp_i = (r >= v);
      ramp_go_i = (r == extra_go_at);
      start_i = (r == start_at);
      @(negedge clk);
    end
    ramp_go_i = 1'b0;
    start_i = 1'b0;
    cmp_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 result after reset", res(), 0);
    chk("R1 done after reset", int'(done_o), 0);
  endtask

  task automatic t_single();
    int d0;
    d0 = done_cnt;
    do_start(0);
    chk("R2 start clears", res(), 0);
    do_conv(1'b0, 10, -1, -1);
    chk("R3 R4 reset phase subtracts count", res(), -12);
    do_conv(1'b1, 50, -1, -1);
    chk("R4 single pair difference", res(), 40);
    chk("R6 done after one pair", done_cnt - d0, 1);
    repeat (10) @(negedge clk);
    chk("R6 result holds after done", res(), 40);
  endtask

  task automatic t_negative();
    int d0;
    d0 = done_cnt;
    do_start(1);
    chk("R2 start clears previous result", res(), 0);
    do_conv(1'b0, 30, -1, -1);
    do_conv(1'b1, 10, -1, -1);
    chk("R6 no done before M-th pair", done_cnt - d0, 0);
    do_conv(1'b0, 20, -1, -1);
    do_conv(1'b1, 20, -1, -1);
    chk("R4 negative two's complement result", res(), -20);
    chk("R6 done after second pair", done_cnt - d0, 1);
  endtask

  task automatic t_gain();
    int d0;
    d0 = done_cnt;
    do_start(2);
    for (int p = 0; p < 4; p++) begin
      do_conv(1'b0, 5, -1, -1);
      do_conv(1'b1, 25, -1, -1);
    end
    chk("R10 four identical pairs give 4x", res(), 80);
    chk("R10 done once", done_cnt - d0, 1);
  endtask

  task automatic t_sat();
    do_start(0);
    do_conv(1'b0, 0, -1, -1);
    do_conv(1'b1, 1000, -1, -1);
    chk("R5 signal saturates at full scale", res(), FULL - 2);
    do_start(0);
    do_conv(1'b0, 1000, -1, -1);
    do_conv(1'b1, 300, -1, -1);
    chk("R5 both phases saturate", res(), 0);
  endtask

  task automatic t_clamp();
    int d0;
    d0 = done_cnt;
    do_start(7);
    for (int p = 0; p < 15; p++) begin
      do_conv(1'b0, 0, -1, -1);
      do_conv(1'b1, 1000, -1, -1);
    end
    chk("R8 no done after 15 pairs", done_cnt - d0, 0);
    chk("R8 partial sum after 15 pairs", res(), 15 * (FULL - 2));
    do_conv(1'b0, 0, -1, -1);
    do_conv(1'b1, 1000, -1, -1);
    chk("R8 clamped M=16 full-scale sum", res(), 16 * (FULL - 2));
    chk("R8 done after 16th pair", done_cnt - d0, 1);
  endtask

  task automatic t_ignore();
    int d0, keep;
    d0 = done_cnt;
    keep = res();
    ramp_go_i = 1'b1;
    cmp_i = 1'b0;
    @(negedge clk);
    ramp_go_i = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 ramp strobe ignored while idle", res(), keep);
    chk("R7 no done while idle", done_cnt - d0, 0);
    do_start(0);
    do_conv(1'b0, 10, 4, -1);
    chk("R7 strobe during reset conversion ignored", res(), -12);
    do_conv(1'b1, 20, 6, -1);
    chk("R7 strobe during signal conversion ignored", res(), 10);
  endtask

  task automatic t_priority();
    int d0;
    d0 = done_cnt;
    do_start(0);
    do_conv(1'b0, 8, -1, -1);
    // count = 32, stop decided in the cycle after edge 32
    do_conv(1'b1, 30, -1, 32);
    chk("R9 start at final stop clears result", res(), 0);
    chk("R9 no done when start collides", done_cnt - d0, 0);
    do_conv(1'b0, 4, -1, -1);
    do_conv(1'b1, 9, -1, -1);
    chk("R9 new sequence result", res(), 5);
    chk("R9 new sequence done", done_cnt - d0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_negative();
    t_gain();
    t_sat();
    t_clamp();
    t_ignore();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule